// File: doc/BRIEF.md
# Presettable Decade Up/Down Counter Stage

This block is one decimal digit of a counter. It holds a value from 0 to 9 and moves it one step on each rising edge of the system clock where exactly one of two strobes is high: the up strobe adds one and the down strobe subtracts one. The direction comes only from which strobe fires; there is no direction-select pin. Both ends wrap around, so 9 goes up to 0 and 0 goes down to 9.

Two controls override the strobes without waiting for the clock. A high level on the clear input forces the digit to zero. A low level on the load input puts the 4-bit preset bus on the output. Clear wins when both are active. Each control is released through a short synchroniser, so the first strobe after release always acts on a settled value. A preset code from 10 to 15 is not a legal digit. From such a code the counter returns to 0..9 along a fixed path.

Two active-low terminal outputs make it easy to chain stages. The carry output goes low while the digit shows 9 and an up strobe is present. The borrow output goes low while the digit shows 0 and a down strobe is present. Feed the inverted carry of one stage to the up strobe of the next, and the inverted borrow to its down strobe, and the stages form a multi-digit decimal counter that steps on one shared clock edge.

Top module: `bcd_updown_stage`

## Requirements
- R1: On a clock edge with the up strobe high and the down strobe low, a digit from 0 to 8 increases by one, and 9 becomes 0.
- R2: On a clock edge with the down strobe high and the up strobe low, a digit from 1 to 9 decreases by one, and 0 becomes 9.
- R3: When both strobes are high, or both are low, the digit keeps its value and neither terminal output goes low.
- R4: carry_n_o is low exactly when count_o equals 9, up_stb_i is high and dn_stb_i is low, and is high otherwise.
- R5: borrow_n_o is low exactly when count_o equals 0, dn_stb_i is high and up_stb_i is low, and is high otherwise.
- R6: While load_n_i is low and clr_i is low, count_o equals preset_i without waiting for a clock edge, and the strobes have no effect.
- R7: While clr_i is high, count_o is 0 without waiting for a clock edge, whatever load_n_i, preset_i and the strobes are.
- R8: After clr_i falls or load_n_i rises, the next SYNC_STAGES clock edges (default 2) keep the digit at 0 or at preset_i respectively and ignore the strobes; the edge after that is the first that counts.
- R9: Counting up from a code above 9 follows 10→11→6, 12→13→4 and 14→15→2.
- R10: Counting down from a code above 9 subtracts one per step (15, 14, ... 10, 9) until the digit is legal.
- R11: Two stages with the inverted carry and borrow of the low stage driving the up and down strobes of the high stage count as a two-digit decimal counter, wrapping 99↔00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the strobes are sampled on its rising edge |
| clr_i | input | 1 | Asynchronous clear to zero, active high, highest priority |
| load_n_i | input | 1 | Asynchronous preset load, active low |
| preset_i | input | 4 | Value loaded while load_n_i is low |
| up_stb_i | input | 1 | Count-up strobe |
| dn_stb_i | input | 1 | Count-down strobe |
| count_o | output | 4 | Current digit, binary coded |
| carry_n_o | output | 1 | Active-low up terminal count |
| borrow_n_o | output | 1 | Active-low down terminal count |

## Verification
Clear and load can overlap, and each can also overlap a count strobe. The bench raises clear while load is low and while a strobe is high, all halfway between clock edges. It expects zero at once and then expects the strobes to be ignored for the whole synchroniser window. The bench also holds the up strobe high while load is released. It expects the preset value to stay for exactly SYNC_STAGES edges and the first increment on the edge after that. A two-stage chain shows that one stage's terminal output and the next stage's count step arrive on the same edge.

// File: rtl/bcd_stage_pkg.sv
package bcd_stage_pkg;

    localparam int          DIGIT_W  = 4;
    localparam logic [3:0]  DIGIT_MAX = 4'd9;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef struct packed {
        digit_t cnt;
    } stage_state_t;

    // Upward successor, including the fixed return path for codes 10..15
    function automatic digit_t next_up(input digit_t v);
        digit_t r;
        case (v)
            4'd9:    r = 4'd0;
            4'd11:   r = 4'd6;
            4'd13:   r = 4'd4;
            4'd15:   r = 4'd2;
            default: r = v + 4'd1;
        endcase
        return r;
    endfunction

    // Downward successor; illegal codes simply decrement toward 9
    function automatic digit_t next_down(input digit_t v);
        digit_t r;
        if (v == 4'd0) r = DIGIT_MAX;
        else           r = v - 4'd1;
        return r;
    endfunction

endpackage

// File: rtl/bcd_release_sync.sv
module bcd_release_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic async_i,
    output logic hold_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] shift_q;
    logic [STAGES-1:0] shift_d;

    generate
        if (STAGES == 1) begin : g_single
            always_comb shift_d = 1'b0;
        end else begin : g_chain
            always_comb shift_d = {shift_q[STAGES-2:0], 1'b0};
        end
    endgenerate

    always_ff @(posedge clk or posedge async_i) begin
        if (async_i) shift_q <= '1;
        else         shift_q <= shift_d;
    end

    assign hold_o = shift_q[LAST];
endmodule

// File: rtl/bcd_step_logic.sv
module bcd_step_logic
    import bcd_stage_pkg::*;
(
    input  digit_t cur_i,
    input  digit_t preset_i,
    input  logic   clr_hold_i,
    input  logic   ld_hold_i,
    input  logic   up_i,
    input  logic   dn_i,
    output digit_t nxt_o
);
    always_comb begin
        nxt_o = cur_i;
        if (clr_hold_i)          nxt_o = '0;
        else if (ld_hold_i)      nxt_o = preset_i;
        else if (up_i && !dn_i)  nxt_o = next_up(cur_i);
        else if (dn_i && !up_i)  nxt_o = next_down(cur_i);
    end
endmodule

// File: rtl/bcd_terminal_decode.sv
module bcd_terminal_decode
    import bcd_stage_pkg::*;
(
    input  digit_t shown_i,
    input  logic   up_i,
    input  logic   dn_i,
    output logic   carry_n_o,
    output logic   borrow_n_o
);
    logic at_top;
    logic at_bottom;

    always_comb begin
        at_top     = (shown_i == DIGIT_MAX);
        at_bottom  = (shown_i == '0);
        carry_n_o  = !(at_top    && up_i && !dn_i);
        borrow_n_o = !(at_bottom && dn_i && !up_i);
    end
endmodule

// File: rtl/bcd_updown_stage.sv
module bcd_updown_stage
    import bcd_stage_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       clr_i,
    input  logic       load_n_i,
    input  logic [3:0] preset_i,
    input  logic       up_stb_i,
    input  logic       dn_stb_i,
    output logic [3:0] count_o,
    output logic       carry_n_o,
    output logic       borrow_n_o
);
    stage_state_t state_q;
    stage_state_t state_d;

    logic   clr_hold;
    logic   ld_hold;
    logic   ld_req;
    digit_t step_nxt;
    digit_t shown;

    assign ld_req = ~load_n_i;

    bcd_release_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
        .clk     (clk),
        .async_i (clr_i),
        .hold_o  (clr_hold)
    );

    bcd_release_sync #(.STAGES(SYNC_STAGES)) u_ld_sync (
        .clk     (clk),
        .async_i (ld_req),
        .hold_o  (ld_hold)
    );

    bcd_step_logic u_step (
        .cur_i      (state_q.cnt),
        .preset_i   (preset_i),
        .clr_hold_i (clr_hold),
        .ld_hold_i  (ld_hold),
        .up_i       (up_stb_i),
        .dn_i       (dn_stb_i),
        .nxt_o      (step_nxt)
    );

    always_comb begin
        state_d     = state_q;
        state_d.cnt = step_nxt;
    end

    always_ff @(posedge clk or posedge clr_i) begin
        if (clr_i) state_q <= '0;
        else       state_q <= state_d;
    end

    // Load shows through at once; clear already zeroed the register
    always_comb begin
        shown = state_q.cnt;
        if (!clr_i && !load_n_i) shown = preset_i;
    end

    assign count_o = shown;

    bcd_terminal_decode u_term (
        .shown_i    (shown),
        .up_i       (up_stb_i),
        .dn_i       (dn_stb_i),
        .carry_n_o  (carry_n_o),
        .borrow_n_o (borrow_n_o)
    );
endmodule

module bcd_updown_stage_chk (
    input logic       clk,
    input logic       clr_i,
    input logic       load_n_i,
    input logic [3:0] preset_i,
    input logic       up_stb_i,
    input logic       dn_stb_i,
    input logic [3:0] count_o,
    input logic       carry_n_o,
    input logic       borrow_n_o,
    input logic       clr_hold,
    input logic       ld_hold
);
    logic free_run;
    assign free_run = !clr_hold && !ld_hold && load_n_i;

    // R7
    clear_zero_chk: assert property (@(posedge clk) clr_i |-> count_o == 4'd0);

    // R6
    load_show_chk: assert property (@(posedge clk) disable iff (clr_i)
        !load_n_i |-> count_o == preset_i);

    // R4
    carry_cause_chk: assert property (@(posedge clk) disable iff (clr_i)
        !carry_n_o |-> (count_o == 4'd9 && up_stb_i && !dn_stb_i));

    // R5
    borrow_cause_chk: assert property (@(posedge clk) disable iff (clr_i)
        !borrow_n_o |-> (count_o == 4'd0 && dn_stb_i && !up_stb_i));

    // R1
    up_step_chk: assert property (@(posedge clk) disable iff (clr_i || !load_n_i)
        (free_run && up_stb_i && !dn_stb_i && count_o < 4'd9)
        |=> count_o == $past(count_o) + 4'd1);

    // R2
    down_step_chk: assert property (@(posedge clk) disable iff (clr_i || !load_n_i)
        (free_run && dn_stb_i && !up_stb_i && count_o != 4'd0)
        |=> count_o == $past(count_o) - 4'd1);

    // R3
    both_hold_chk: assert property (@(posedge clk) disable iff (clr_i || !load_n_i)
        (free_run && up_stb_i && dn_stb_i) |=> $stable(count_o));

    // R8
    clear_recover_chk: assert property (@(posedge clk) disable iff (clr_i || !load_n_i)
        clr_hold |=> count_o == 4'd0);
endmodule

bind bcd_updown_stage bcd_updown_stage_chk u_chk (
    .clk        (clk),
    .clr_i      (clr_i),
    .load_n_i   (load_n_i),
    .preset_i   (preset_i),
    .up_stb_i   (up_stb_i),
    .dn_stb_i   (dn_stb_i),
    .count_o    (count_o),
    .carry_n_o  (carry_n_o),
    .borrow_n_o (borrow_n_o),
    .clr_hold   (clr_hold),
    .ld_hold    (ld_hold)
);

// File: tb/bcd_updown_stage_bench.sv
module bcd_updown_stage_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 20;

    // {preset[11:8], up[7], dn[6], expected next[5:2], carry_n[1], borrow_n[0]}
    localparam logic [11:0] VEC [NVEC] = '{
        {4'd0,  1'b1, 1'b0, 4'd1,  1'b1, 1'b1},  // R1
        {4'd5,  1'b1, 1'b0, 4'd6,  1'b1, 1'b1},  // R1
        {4'd8,  1'b1, 1'b0, 4'd9,  1'b1, 1'b1},  // R1 R4
        {4'd9,  1'b1, 1'b0, 4'd0,  1'b0, 1'b1},  // R1 R4
        {4'd9,  1'b0, 1'b1, 4'd8,  1'b1, 1'b1},  // R2
        {4'd0,  1'b0, 1'b1, 4'd9,  1'b1, 1'b0},  // R2 R5
        {4'd1,  1'b0, 1'b1, 4'd0,  1'b1, 1'b1},  // R2 R5
        {4'd10, 1'b1, 1'b0, 4'd11, 1'b1, 1'b1},  // R9
        {4'd11, 1'b1, 1'b0, 4'd6,  1'b1, 1'b1},  // R9
        {4'd12, 1'b1, 1'b0, 4'd13, 1'b1, 1'b1},  // R9
        {4'd13, 1'b1, 1'b0, 4'd4,  1'b1, 1'b1},  // R9
        {4'd14, 1'b1, 1'b0, 4'd15, 1'b1, 1'b1},  // R9
        {4'd15, 1'b1, 1'b0, 4'd2,  1'b1, 1'b1},  // R9
        {4'd15, 1'b0, 1'b1, 4'd14, 1'b1, 1'b1},  // R10
        {4'd10, 1'b0, 1'b1, 4'd9,  1'b1, 1'b1},  // R10
        {4'd5,  1'b1, 1'b1, 4'd5,  1'b1, 1'b1},  // R3
        {4'd9,  1'b1, 1'b1, 4'd9,  1'b1, 1'b1},  // R3
        {4'd0,  1'b1, 1'b1, 4'd0,  1'b1, 1'b1},  // R3
        {4'd3,  1'b0, 1'b0, 4'd3,  1'b1, 1'b1},  // R3
        {4'd9,  1'b0, 1'b0, 4'd9,  1'b1, 1'b1}   // R3
    };

    logic       clk = 1'b0;
    logic       clr_i = 1'b1;
    logic       load_n_i = 1'b1;
    logic [3:0] preset_i = 4'd0;
    logic       up_stb_i = 1'b0;
    logic       dn_stb_i = 1'b0;
    logic [3:0] count_o;
    logic       carry_n_o;
    logic       borrow_n_o;
    logic [3:0] hi_count;
    logic       hi_carry_n;
    logic       hi_borrow_n;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_updown_stage u_bcd_updown_stage (
        .clk(clk), .clr_i(clr_i), .load_n_i(load_n_i), .preset_i(preset_i),
        .up_stb_i(up_stb_i), .dn_stb_i(dn_stb_i), .count_o(count_o),
        .carry_n_o(carry_n_o), .borrow_n_o(borrow_n_o)
    );

    // Second digit for the cascade check (R11)
    bcd_updown_stage u_bcd_updown_stage_hi (
        .clk(clk), .clr_i(clr_i), .load_n_i(1'b1), .preset_i(4'd0),
        .up_stb_i(~carry_n_o), .dn_stb_i(~borrow_n_o), .count_o(hi_count),
        .carry_n_o(hi_carry_n), .borrow_n_o(hi_borrow_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    // Load a value and wait out the release window; returns at a negedge
    task automatic load_val(input logic [3:0] v);
        @(negedge clk);
        up_stb_i = 1'b0; dn_stb_i = 1'b0;
        preset_i = v; load_n_i = 1'b0;
        @(negedge clk);
        load_n_i = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int expv;
        #1;
        // R7 reset state
        chk("R7 count in clear", int'(count_o), 0);
        chk("R4 carry idle", int'(carry_n_o), 1);
        chk("R5 borrow idle", int'(borrow_n_o), 1);
        repeat (2) @(negedge clk);
        clr_i = 1'b0;
        repeat (3) @(negedge clk);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            load_val(VEC[i][11:8]);
            up_stb_i = VEC[i][7];
            dn_stb_i = VEC[i][6];
            #1;
            chk("R4 carry_n", int'(carry_n_o), int'(VEC[i][1]));
            chk("R5 borrow_n", int'(borrow_n_o), int'(VEC[i][0]));
            @(negedge clk);
            chk("R1/R2/R3/R9/R10 next count", int'(count_o), int'(VEC[i][5:2]));
            up_stb_i = 1'b0; dn_stb_i = 1'b0;
        end

        // R6 asynchronous load mid-phase, strobes ignored
        load_val(4'd2);
        #2;
        preset_i = 4'd4; load_n_i = 1'b0; up_stb_i = 1'b1;
        #1;
        chk("R6 load shows at once", int'(count_o), 4);
        repeat (2) @(negedge clk);
        chk("R6 strobe ignored under load", int'(count_o), 4);
        // R8 release of load with up held high
        load_n_i = 1'b1;
        @(negedge clk);
        chk("R8 load hold edge 1", int'(count_o), 4);
        @(negedge clk);
        chk("R8 load hold edge 2", int'(count_o), 4);
        @(negedge clk);
        chk("R8 first count after load", int'(count_o), 5);
        up_stb_i = 1'b0;

        // R7 clear mid-phase, with load active and a strobe high
        load_val(4'd7);
        #2;
        dn_stb_i = 1'b1; load_n_i = 1'b0; preset_i = 4'd6; clr_i = 1'b1;
        #1;
        chk("R7 clear beats load", int'(count_o), 0);
        @(negedge clk);
        load_n_i = 1'b1;
        dn_stb_i = 1'b0; up_stb_i = 1'b1;
        @(negedge clk);
        chk("R7 clear holds with strobe", int'(count_o), 0);
        // R8 release of clear with up held high
        clr_i = 1'b0;
        @(negedge clk);
        chk("R8 clear hold edge 1", int'(count_o), 0);
        @(negedge clk);
        chk("R8 clear hold edge 2", int'(count_o), 0);
        @(negedge clk);
        chk("R8 first count after clear", int'(count_o), 1);
        up_stb_i = 1'b0;

        // R11 cascade: clear both digits, count up 25 then down 30
        @(negedge clk);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        repeat (3) @(negedge clk);
        expv = 0;
        up_stb_i = 1'b1;
        for (int k = 0; k < 25; k++) begin
            @(negedge clk);
            expv = (expv + 1) % 100;
            chk("R11 cascade up", int'(hi_count) * 10 + int'(count_o), expv);
        end
        up_stb_i = 1'b0; dn_stb_i = 1'b1;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            expv = (expv + 99) % 100;
            chk("R11 cascade down", int'(hi_count) * 10 + int'(count_o), expv);
        end
        dn_stb_i = 1'b0;
        @(negedge clk);
        chk("R11 final value", int'(hi_count) * 10 + int'(count_o), 95);

        finish_run();
    end
endmodule